// File: doc/BRIEF.md
# Run-Length Bitstream Expander

This block turns a byte-coded, run-length compressed configuration image into a plain serial bit stream. Bytes arrive on a valid/ready input with an end-of-image flag. The block first discards everything up to and including a two-byte sync marker. It then sends a fixed 16-bit lead-in. After that, each code byte expands into a run of identical bits, which may be closed by one opposite bit.

Bits leave one per transfer on a valid/ready output. A downstream serial shifter therefore sets the pace, and the block stalls cleanly under backpressure. When the last bit of the image has been taken, a one-cycle done pulse is raised. The block then goes back to searching for the next marker.

Top module: `rl_bitstream_expander`

## Requirements
- R1: After reset, `bit_valid` and `done` are 0 and `in_ready` is 1.
- R2: In the search phase, bytes are consumed with no output. The marker is a byte 0xFF immediately followed by a byte whose bits [7:4] equal 4'h3. Both marker bytes are consumed and never decoded, and 0xFF 0xFF 0x3x also matches.
- R3: Right after the marker, the block sends the 16 bits of 16'hFF20, most significant bit first, before any decoded bit.
- R4: A code n in 1..226 gives n one-bits followed by one zero-bit.
- R5: Code 227 gives 226 one-bits and no closing bit.
- R6: A code n in 228..254 gives n-228 zero-bits followed by one one-bit, so code 228 gives a single one-bit.
- R7: Code 255 gives a single one-bit.
- R8: Code 0 gives no bits and is simply consumed.
- R9: While any run, closing bit or lead-in bit is still waiting to be emitted, `in_ready` stays 0.
- R10: While `bit_valid` is 1 and `bit_ready` is 0, `bit_valid` stays 1 and `bit_data` holds its value into the next cycle.
- R11: In the cycle after the final output bit of an image is handed over, `done` is 1 for exactly one cycle, and the block returns to the search phase. Code bytes are consumed in order.
- R12: If the byte flagged last arrives during the search phase, `done` pulses once with no bits sent, and the search starts over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte is present |
| in_data | input | 8 | Compressed image byte |
| in_last | input | 1 | Marks the final byte of an image |
| in_ready | output | 1 | Block accepts the byte this cycle |
| bit_valid | output | 1 | Output bit is present |
| bit_data | output | 1 | Expanded output bit |
| bit_ready | input | 1 | Downstream takes the bit this cycle |
| done | output | 1 | One-cycle pulse after the image's final bit |

## Verification
Single-code images cover each code range at its edges: 1, 226, 227, 228, 254 and 255, plus 0 and values inside the ranges. Comparing bit count, ones count, and first and last bit separates the closed-ones, open-ones, zeros-then-one and lone-one codes. A mixed image (3, 0, 230, 255) is checked bit by bit, so it catches misordered runs and a stray bit from code 0. Headers with junk, a near-miss marker and a doubled 0xFF test the marker search. Random output backpressure and a long open run test the stall and input-blocking behaviour.

// File: rtl/rlx_pkg.sv
package rlx_pkg;
  localparam int RLX_BW = 8;

  typedef enum logic {
    PH_SEEK   = 1'b0,
    PH_EXPAND = 1'b1
  } phase_t;

  typedef struct packed {
    logic [RLX_BW-1:0] len;
    logic              run_bit;
    logic              term_en;
    logic              term_bit;
  } run_desc_t;
endpackage

// File: rtl/rlx_marker_scan.sv
module rlx_marker_scan #(
  parameter int                BW       = 8,
  parameter int                NIB_W    = 4,
  parameter logic [BW-1:0]     HEAD_VAL = 8'hFF,
  parameter logic [NIB_W-1:0]  SYNC_NIB = 4'h3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic          clear,
  input  logic [BW-1:0] byte_i,
  output logic          hit
);
  logic prev_head;

  assign hit = take && prev_head && (byte_i[BW-1 -: NIB_W] == SYNC_NIB);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      prev_head <= 1'b0;
    end else if (take) begin
      prev_head <= (byte_i == HEAD_VAL);
    end
  end
endmodule

// File: rtl/rlx_code_decode.sv
module rlx_code_decode #(
  parameter int BW         = 8,
  parameter int ONES_LIMIT = 226
) (
  input  logic [BW-1:0] code,
  output logic [BW-1:0] run_len,
  output logic          run_bit,
  output logic          term_en,
  output logic          term_bit
);
  localparam logic [BW-1:0] C_LIM   = BW'(ONES_LIMIT);
  localparam logic [BW-1:0] C_OPEN  = BW'(ONES_LIMIT + 1);
  localparam logic [BW-1:0] C_ZBASE = BW'(ONES_LIMIT + 2);
  localparam logic [BW-1:0] C_MAX   = '1;

  always_comb begin
    run_len  = '0;
    run_bit  = 1'b0;
    term_en  = 1'b0;
    term_bit = 1'b0;
    if (code == '0) begin
      run_len = '0;
    end else if (code <= C_LIM) begin
      run_len = code;
      run_bit = 1'b1;
      term_en = 1'b1;
    end else if (code == C_OPEN) begin
      run_len = C_LIM;
      run_bit = 1'b1;
    end else if (code != C_MAX) begin
      run_len  = code - C_ZBASE;
      term_en  = 1'b1;
      term_bit = 1'b1;
    end else begin
      term_en  = 1'b1;
      term_bit = 1'b1;
    end
  end
endmodule

// File: rtl/rlx_bit_emitter.sv
module rlx_bit_emitter #(
  parameter int              BW         = 8,
  parameter int              ONES_LIMIT = 226,
  parameter int              LEAD_W     = 16,
  parameter logic [LEAD_W-1:0] LEAD_PAT = 16'hFF20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_lead,
  input  logic          load_run,
  input  logic [BW-1:0] run_len,
  input  logic          run_bit,
  input  logic          term_en,
  input  logic          term_bit,
  input  logic          out_ready,
  output logic          out_valid,
  output logic          out_data,
  output logic          idle
);
  localparam int LCW = $clog2(LEAD_W + 1);

  logic [LEAD_W-1:0] lead_sh;
  logic [LCW-1:0]    lead_cnt;
  logic [BW-1:0]     cnt;
  logic              rbit, tpend, tbit;
  logic              ov, od;
  logic              can_load;

  assign can_load  = !ov || out_ready;
  assign idle      = (lead_cnt == '0) && (cnt == '0) && !tpend;
  assign out_valid = ov;
  assign out_data  = od;

  always_ff @(posedge clk) begin
    if (rst) begin
      lead_sh  <= '0;
      lead_cnt <= '0;
      cnt      <= '0;
      rbit     <= 1'b0;
      tpend    <= 1'b0;
      tbit     <= 1'b0;
      ov       <= 1'b0;
      od       <= 1'b0;
    end else begin
      if (can_load) begin
        if (lead_cnt != '0) begin
          ov       <= 1'b1;
          od       <= lead_sh[LEAD_W-1];
          lead_sh  <= lead_sh << 1;
          lead_cnt <= lead_cnt - 1'b1;
        end else if (cnt != '0) begin
          ov  <= 1'b1;
          od  <= rbit;
          cnt <= cnt - 1'b1;
        end else if (tpend) begin
          ov    <= 1'b1;
          od    <= tbit;
          tpend <= 1'b0;
        end else begin
          ov <= 1'b0;
        end
      end
      if (load_lead) begin
        lead_sh  <= LEAD_PAT;
        lead_cnt <= LCW'(LEAD_W);
      end
      if (load_run) begin
        cnt   <= run_len;
        rbit  <= run_bit;
        tpend <= term_en;
        tbit  <= term_bit;
      end
    end
  end

  a_r10_hold_when_stalled: assert property (@(posedge clk) disable iff (rst)
    (ov && !out_ready) |=> (ov && $stable(od)));

  a_r3_lead_before_runs: assert property (@(posedge clk) disable iff (rst)
    (lead_cnt != '0) |-> ((cnt == '0) && !tpend));

  a_r5_run_bounded: assert property (@(posedge clk) disable iff (rst)
    cnt <= BW'(ONES_LIMIT));
endmodule

// File: rtl/rl_bitstream_expander.sv
module rl_bitstream_expander
  import rlx_pkg::*;
#(
  parameter int              ONES_LIMIT = 226,
  parameter int              LEAD_W     = 16,
  parameter logic [LEAD_W-1:0] LEAD_PAT = 16'hFF20,
  parameter logic [7:0]      HEAD_VAL   = 8'hFF,
  parameter logic [3:0]      SYNC_NIB   = 4'h3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_last,
  output logic       in_ready,
  output logic       bit_valid,
  output logic       bit_data,
  input  logic       bit_ready,
  output logic       done
);
  localparam int BW = RLX_BW;

  phase_t    ph;
  logic      end_pend, done_r;
  logic      acc, hit, fin, em_idle;
  run_desc_t desc;

  assign in_ready = !end_pend && ((ph == PH_SEEK) || em_idle);
  assign acc      = in_valid && in_ready;
  assign fin      = end_pend && em_idle && (!bit_valid || bit_ready);
  assign done     = done_r;

  rlx_marker_scan #(
    .BW(BW), .NIB_W(4), .HEAD_VAL(HEAD_VAL), .SYNC_NIB(SYNC_NIB)
  ) u_scan (
    .clk(clk), .rst(rst),
    .take(acc && (ph == PH_SEEK)),
    .clear(fin),
    .byte_i(in_data),
    .hit(hit)
  );

  rlx_code_decode #(.BW(BW), .ONES_LIMIT(ONES_LIMIT)) u_dec (
    .code(in_data),
    .run_len(desc.len),
    .run_bit(desc.run_bit),
    .term_en(desc.term_en),
    .term_bit(desc.term_bit)
  );

  rlx_bit_emitter #(
    .BW(BW), .ONES_LIMIT(ONES_LIMIT), .LEAD_W(LEAD_W), .LEAD_PAT(LEAD_PAT)
  ) u_emit (
    .clk(clk), .rst(rst),
    .load_lead(hit),
    .load_run(acc && (ph == PH_EXPAND)),
    .run_len(desc.len),
    .run_bit(desc.run_bit),
    .term_en(desc.term_en),
    .term_bit(desc.term_bit),
    .out_ready(bit_ready),
    .out_valid(bit_valid),
    .out_data(bit_data),
    .idle(em_idle)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= PH_SEEK;
      end_pend <= 1'b0;
      done_r   <= 1'b0;
    end else if (fin) begin
      ph       <= PH_SEEK;
      end_pend <= 1'b0;
      done_r   <= 1'b1;
    end else begin
      done_r <= 1'b0;
      if (acc && in_last) end_pend <= 1'b1;
      if (hit) ph <= PH_EXPAND;
    end
  end

  a_r11_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r11_done_after_drain: assert property (@(posedge clk) disable iff (rst)
    done |-> !bit_valid);

  a_r2_silent_while_seeking: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_SEEK) |-> !bit_valid);

  a_r9_no_take_after_last: assert property (@(posedge clk) disable iff (rst)
    (acc && in_last) |=> !in_ready);
endmodule

// File: tb/rl_bitstream_expander_bench.sv
`timescale 1ns/1ps
module rl_bitstream_expander_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_last = 1'b0;
  logic       in_ready;
  logic       bit_valid, bit_data;
  logic       bit_ready = 1'b0;
  logic       done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  rl_bitstream_expander u_rl_bitstream_expander (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_ready(in_ready),
    .bit_valid(bit_valid), .bit_data(bit_data), .bit_ready(bit_ready),
    .done(done)
  );

  // fields: code[27:20] nbits[19:11] ones[10:2] first[1] last[0]
  localparam int NV = 10;
  localparam logic [27:0] VEC [NV] = '{
    {8'd1,   9'd2,   9'd1,   1'b1, 1'b0},   // R4 low edge
    {8'd5,   9'd6,   9'd5,   1'b1, 1'b0},   // R4
    {8'd100, 9'd101, 9'd100, 1'b1, 1'b0},   // R4
    {8'd226, 9'd227, 9'd226, 1'b1, 1'b0},   // R4 high edge
    {8'd227, 9'd226, 9'd226, 1'b1, 1'b1},   // R5
    {8'd228, 9'd1,   9'd1,   1'b1, 1'b1},   // R6 low edge
    {8'd229, 9'd2,   9'd1,   1'b0, 1'b1},   // R6
    {8'd254, 9'd27,  9'd1,   1'b0, 1'b1},   // R6 high edge
    {8'd255, 9'd1,   9'd1,   1'b1, 1'b1},   // R7
    {8'd0,   9'd0,   9'd0,   1'b0, 1'b0}    // R8
  };

  logic cap [0:8191];
  int   cap_n = 0;
  int   done_n = 0;
  int   cyc = 0;
  int   hs_cyc = 0;
  int   done_cyc = 0;
  int   stab_bad = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic prev_stall = 1'b0;
  logic prev_data = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst) begin
      if (prev_stall && !(bit_valid && bit_data == prev_data)) stab_bad++;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      bit_ready = lfsr[0] | lfsr[1];
      if (bit_valid && bit_ready) begin
        cap[cap_n] = bit_data;
        cap_n++;
        hs_cyc = cyc;
      end
      prev_stall = bit_valid && !bit_ready;
      prev_data  = bit_data;
      if (done) begin
        done_n++;
        done_cyc = cyc;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input logic l);
    logic hs;
    hs = 1'b0;
    in_valid = 1'b1;
    in_data  = b;
    in_last  = l;
    while (!hs) begin
      hs = in_ready;
      @(posedge clk);
      if (!hs) @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic wait_done(input int d0);
    while (done_n == d0) @(negedge clk);
  endtask

  function automatic string req_of(input logic [7:0] c);
    if (c == 8'd0)   return "R8";
    if (c <= 8'd226) return "R4";
    if (c == 8'd227) return "R5";
    if (c == 8'd255) return "R7";
    return "R6";
  endfunction

  task automatic check_lead(input int base);
    int bad;
    bad = 0;
    for (int k = 0; k < 16; k++)
      if (cap[base + k] != ((16'hFF20 >> (15 - k)) & 1)) bad++;
    chk(bad == 0, "R3", "lead-in mismatching bits", bad, 0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(bit_valid == 1'b0, "R1", "bit_valid after reset", int'(bit_valid), 0);
    chk(done == 1'b0, "R1", "done after reset", int'(done), 0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);

    // table walk: one single-code image per vector
    for (int v = 0; v < NV; v++) begin
      logic [7:0] code;
      int nb, on, base, d0, ones;
      code = VEC[v][27:20];
      nb   = int'(VEC[v][19:11]);
      on   = int'(VEC[v][10:2]);
      base = cap_n;
      d0   = done_n;
      send_byte(8'h12, 1'b0);
      send_byte(8'hFF, 1'b0);
      send_byte(8'h37, 1'b0);
      send_byte(code, 1'b1);
      wait_done(d0);
      @(negedge clk);
      chk(cap_n - base - 16 == nb, req_of(code), "payload bit count", cap_n - base - 16, nb);
      check_lead(base);
      ones = 0;
      for (int k = base + 16; k < cap_n; k++) ones += int'(cap[k]);
      chk(ones == on, req_of(code), "payload ones", ones, on);
      if (nb > 0) begin
        chk(cap[base + 16] == VEC[v][1], req_of(code), "first payload bit",
            int'(cap[base + 16]), int'(VEC[v][1]));
        chk(cap[cap_n - 1] == VEC[v][0], req_of(code), "last payload bit",
            int'(cap[cap_n - 1]), int'(VEC[v][0]));
        chk(done_cyc == hs_cyc + 1, "R11", "done timing vs final bit", done_cyc, hs_cyc + 1);
      end
      chk(done_n == d0 + 1, "R11", "done pulses per image", done_n - d0, 1);
    end

    // R2: junk, near-miss marker, doubled 0xFF before the real marker
    begin
      int base, d0;
      base = cap_n;
      d0 = done_n;
      send_byte(8'h55, 1'b0);
      send_byte(8'hFF, 1'b0);
      send_byte(8'h20, 1'b0);
      send_byte(8'h31, 1'b0);
      chk(cap_n == base, "R2", "bits during search", cap_n - base, 0);
      send_byte(8'hFF, 1'b0);
      send_byte(8'hFF, 1'b0);
      send_byte(8'h3C, 1'b0);
      repeat (60) @(negedge clk);
      chk(cap_n - base == 16, "R2", "bits after marker only", cap_n - base, 16);
      check_lead(base);
      send_byte(8'd255, 1'b1);
      wait_done(d0);
      @(negedge clk);
      chk(cap_n - base == 17, "R2", "marker bytes not decoded", cap_n - base, 17);
    end

    // R8/R11: mixed image 3,0,230,255 -> 1110 . 001 1
    begin
      int base, d0, bad;
      logic [7:0] exp_bits;
      exp_bits = 8'b1110_0011;
      base = cap_n;
      d0 = done_n;
      send_byte(8'hFF, 1'b0);
      send_byte(8'h30, 1'b0);
      send_byte(8'd3, 1'b0);
      send_byte(8'd0, 1'b0);
      send_byte(8'd230, 1'b0);
      send_byte(8'd255, 1'b1);
      wait_done(d0);
      @(negedge clk);
      chk(cap_n - base == 24, "R8", "mixed image length", cap_n - base, 24);
      bad = 0;
      for (int k = 0; k < 8; k++)
        if (cap[base + 16 + k] != exp_bits[7 - k]) bad++;
      chk(bad == 0, "R11", "mixed image bit order errors", bad, 0);
    end

    // R9: long open run blocks input
    begin
      int base, d0;
      base = cap_n;
      d0 = done_n;
      send_byte(8'hFF, 1'b0);
      send_byte(8'h3F, 1'b0);
      send_byte(8'd227, 1'b0);
      repeat (4) @(negedge clk);
      chk(in_ready == 1'b0, "R9", "in_ready during pending run", int'(in_ready), 0);
      send_byte(8'd1, 1'b1);
      wait_done(d0);
      @(negedge clk);
      chk(cap_n - base == 16 + 228, "R9", "run then next code length", cap_n - base, 244);
      chk(cap[cap_n - 1] == 1'b0 && cap[cap_n - 2] == 1'b1, "R9", "tail bits",
          int'({cap[cap_n - 2], cap[cap_n - 1]}), 2);
    end

    // R12: last byte during search
    begin
      int base, d0;
      base = cap_n;
      d0 = done_n;
      send_byte(8'h11, 1'b0);
      send_byte(8'hFF, 1'b1);
      wait_done(d0);
      @(negedge clk);
      chk(cap_n == base, "R12", "bits for marker-less image", cap_n - base, 0);
      chk(done_n == d0 + 1, "R12", "done pulses", done_n - d0, 1);
      // prior 0xFF must not pair with a 0x3x after restart
      send_byte(8'h35, 1'b0);
      repeat (30) @(negedge clk);
      chk(cap_n == base, "R12", "search restarted clean", cap_n - base, 0);
    end

    chk(stab_bad == 0, "R10", "stall stability violations", stab_bad, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule